// File: doc/BRIEF.md
# Burst Read-Increment-Write Engine

This block is a bus master on an AXI4 memory interface. A one-cycle start request launches a single operation. The engine fetches one incrementing read burst from a read base address and sends one incrementing write burst to a write base address. Each read beat is passed straight through as a write beat carrying the read value plus one.

The write side uses every byte lane of each beat, and the final write beat is flagged as last. Once that beat has been accepted, the engine waits for the write response and keeps its code. It then pulses a completion signal for one cycle.

A sticky error flag records any non-zero read or write response seen during the operation. Software or a sequencer can inspect the flag and the response code after completion. The next accepted start clears the flag.

Top module: `burst_incr_copier`

## Requirements
- R1: While reset is held and right after it, ready is 1, finish is 0, err_seen is 0, and ar_valid, aw_valid, w_valid, r_ready and b_ready are all 0.
- R2: One cycle after an accepted start, the engine raises ar_valid and aw_valid. ar_addr carries rd_base and aw_addr carries wr_base. Both length fields read BEATS-1 (255 by default), both burst fields read 2'b01 (incrementing), and both size fields read 3'd3 (8-byte beats). Each request is held stable until its ready is seen, and each is issued exactly once per operation.
- R3: The data of the k-th write beat equals the k-th read beat plus one, modulo 2^64, so all-ones wraps to zero. w_strb is 8'hFF on every beat.
- R4: Exactly BEATS write beats are sent per operation. w_last is 1 on the final beat and 0 on all others.
- R5: No write beat is offered while aw_valid is still waiting for its handshake.
- R6: A stalled write beat (w_valid=1, w_ready=0) keeps its data and last flag unchanged until it is accepted. No read beat is lost or duplicated under random stalls on any channel.
- R7: b_ready is raised only after the last write beat has been accepted. The 2-bit b_resp taken at the handshake appears on resp_code.
- R8: finish is a single-cycle pulse in the cycle after the write-response handshake, and ready is 1 in that same cycle.
- R9: When no channel ever stalls, finish rises BEATS+3 cycles after the clock edge that accepts start (259 cycles with the defaults).
- R10: err_seen becomes 1 after any read beat with non-zero r_resp or a non-zero b_resp, stays 1 to the end of the operation, and is cleared by the next accepted start.
- R11: A start pulse while ready is 0 is ignored: no second read or write request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, accepted when ready is 1 |
| rd_base | input | 32 | Read burst start address |
| wr_base | input | 32 | Write burst start address |
| ready | output | 1 | Engine idle, start will be accepted |
| finish | output | 1 | One-cycle completion pulse |
| resp_code | output | 2 | Captured write response code |
| err_seen | output | 1 | Sticky non-zero response flag |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | 32 | Read address |
| ar_len | output | 8 | Read burst length minus one |
| ar_burst | output | 2 | Read burst type |
| ar_size | output | 3 | Read beat size code |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Write address |
| aw_len | output | 8 | Write burst length minus one |
| aw_burst | output | 2 | Write burst type |
| aw_size | output | 3 | Write beat size code |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | 64 | Write data |
| w_strb | output | 8 | Write byte strobes |
| w_last | output | 1 | Final write beat |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | 64 | Read data |
| r_resp | input | 2 | Read response |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response code |

## Verification
The address requests are due in the first cycle after the start edge. With the default output register, each write beat is due one cycle after the read handshake that feeds it. The finish pulse is due exactly one cycle after the write-response handshake, and with no stalls that pulse lands BEATS+3 cycles after start.

The bench drives every input at the falling edge. It settles briefly, then records each handshake as valid and ready seen together before the next rising edge. Its expectations are indexed by that cycle count: the request check sits at cycle 1, finish is compared against the response handshake cycle plus one, and the stall-free runs compare the finish cycle against BEATS+3.

// File: rtl/bic_pkg.sv
package bic_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_RESP = 2'd2
   } phase_t;

   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/bic_addr_chan.sv
// Presents one address request per launch and holds it until accepted.
module bic_addr_chan #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          launch,
   input  logic [AW-1:0] base,
   input  logic          ready_in,
   output logic          valid_o,
   output logic [AW-1:0] addr_o,
   output logic          done_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         done_o  <= 1'b0;
      end else if (launch) begin
         valid_o <= 1'b1;
         addr_o  <= base;
         done_o  <= 1'b0;
      end else if (valid_o && ready_in) begin
         valid_o <= 1'b0;
         done_o  <= 1'b1;
      end
   end
endmodule

// File: rtl/bic_beat_xfer.sv
// Moves read beats to the write channel as value plus one.
module bic_beat_xfer #(
   parameter int DW    = 64,
   parameter int BEATS = 256,
   parameter bit W_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            launch,
   input  logic            enable,
   input  logic            r_valid,
   input  logic [DW-1:0]   r_data,
   input  logic [1:0]      r_resp,
   output logic            r_ready,
   output logic            w_valid,
   output logic [DW-1:0]   w_data,
   output logic [DW/8-1:0] w_strb,
   output logic            w_last,
   input  logic            w_ready,
   output logic            last_done,
   output logic            rerr
);
   localparam int CNT_W = $clog2(BEATS + 1);
   localparam logic [CNT_W-1:0] FINAL_IDX = CNT_W'(BEATS - 1);
   localparam logic [CNT_W-1:0] ALL_BEATS = CNT_W'(BEATS);

   logic [CNT_W-1:0] rd_cnt;
   logic             rd_full;
   logic             take;

   assign rd_full   = (rd_cnt == ALL_BEATS);
   assign take      = r_valid && r_ready;
   assign w_strb    = '1;
   assign last_done = w_valid && w_ready && w_last;
   assign rerr      = take && (r_resp != bic_pkg::RESP_OKAY);

   always_ff @(posedge clk) begin
      if (rst || launch)
         rd_cnt <= '0;
      else if (take)
         rd_cnt <= rd_cnt + 1'b1;
   end

   generate
      if (W_REG) begin : g_reg
         logic          wv_q;
         logic [DW-1:0] wd_q;
         logic          wl_q;

         assign r_ready = enable && !rd_full && (!wv_q || w_ready);
         assign w_valid = wv_q;
         assign w_data  = wd_q;
         assign w_last  = wl_q;

         always_ff @(posedge clk) begin
            if (rst || launch) begin
               wv_q <= 1'b0;
               wd_q <= '0;
               wl_q <= 1'b0;
            end else if (take) begin
               wv_q <= 1'b1;
               wd_q <= r_data + 1'b1;
               wl_q <= (rd_cnt == FINAL_IDX);
            end else if (w_ready) begin
               wv_q <= 1'b0;
            end
         end
      end else begin : g_pass
         assign r_ready = enable && !rd_full && w_ready;
         assign w_valid = enable && !rd_full && r_valid;
         assign w_data  = r_data + 1'b1;
         assign w_last  = (rd_cnt == FINAL_IDX);
      end
   endgenerate
endmodule

// File: rtl/bic_resp_trk.sv
// Captures the write response, tracks sticky errors, forms the finish pulse.
module bic_resp_trk (
   input  logic       clk,
   input  logic       rst,
   input  logic       launch,
   input  logic       b_ready,
   input  logic       b_valid,
   input  logic [1:0] b_resp,
   input  logic       rerr,
   output logic [1:0] code_o,
   output logic       err_o,
   output logic       fin_o
);
   logic b_take;
   assign b_take = b_valid && b_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_o <= bic_pkg::RESP_OKAY;
         err_o  <= 1'b0;
         fin_o  <= 1'b0;
      end else begin
         fin_o <= b_take;
         if (launch)
            err_o <= 1'b0;
         else if (rerr || (b_take && b_resp != bic_pkg::RESP_OKAY))
            err_o <= 1'b1;
         if (b_take)
            code_o <= b_resp;
      end
   end
endmodule

// File: rtl/burst_incr_copier.sv
module burst_incr_copier #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int LEN_W = 8,
   parameter int BEATS = 256,
   parameter bit W_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [AW-1:0]   rd_base,
   input  logic [AW-1:0]   wr_base,
   output logic            ready,
   output logic            finish,
   output logic [1:0]      resp_code,
   output logic            err_seen,
   output logic            ar_valid,
   input  logic            ar_ready,
   output logic [AW-1:0]   ar_addr,
   output logic [LEN_W-1:0] ar_len,
   output logic [1:0]      ar_burst,
   output logic [2:0]      ar_size,
   output logic            aw_valid,
   input  logic            aw_ready,
   output logic [AW-1:0]   aw_addr,
   output logic [LEN_W-1:0] aw_len,
   output logic [1:0]      aw_burst,
   output logic [2:0]      aw_size,
   output logic            w_valid,
   input  logic            w_ready,
   output logic [DW-1:0]   w_data,
   output logic [DW/8-1:0] w_strb,
   output logic            w_last,
   input  logic            r_valid,
   output logic            r_ready,
   input  logic [DW-1:0]   r_data,
   input  logic [1:0]      r_resp,
   input  logic            b_valid,
   output logic            b_ready,
   input  logic [1:0]      b_resp
);
   import bic_pkg::*;

   localparam int                BYTES   = DW / 8;
   localparam logic [2:0]        SIZE_CD = 3'($clog2(BYTES));
   localparam logic [LEN_W-1:0]  LEN_CD  = LEN_W'(BEATS - 1);

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("DW must be a whole number of bytes");
      end
      if (BEATS < 1 || BEATS > (1 << LEN_W)) begin : g_bad_beats
         $error("BEATS must fit the length field");
      end
      if (AW < 12) begin : g_bad_aw
         $error("AW too narrow");
      end
   endgenerate

   phase_t phase;
   logic   launch, ar_done, aw_done, last_done, rerr, enable;

   assign launch  = start && (phase == PH_IDLE);
   assign ready   = (phase == PH_IDLE);
   assign b_ready = (phase == PH_RESP);
   assign enable  = (phase == PH_RUN) && aw_done;

   always_ff @(posedge clk) begin
      if (rst)
         phase <= PH_IDLE;
      else begin
         case (phase)
            PH_IDLE: if (launch)              phase <= PH_RUN;
            PH_RUN:  if (last_done)           phase <= PH_RESP;
            PH_RESP: if (b_valid && b_ready)  phase <= PH_IDLE;
            default:                          phase <= PH_IDLE;
         endcase
      end
   end

   assign ar_len   = LEN_CD;
   assign aw_len   = LEN_CD;
   assign ar_burst = BURST_INCR;
   assign aw_burst = BURST_INCR;
   assign ar_size  = SIZE_CD;
   assign aw_size  = SIZE_CD;

   bic_addr_chan #(.AW(AW)) u_ar (
      .clk(clk), .rst(rst), .launch(launch), .base(rd_base),
      .ready_in(ar_ready), .valid_o(ar_valid), .addr_o(ar_addr), .done_o(ar_done)
   );

   bic_addr_chan #(.AW(AW)) u_aw (
      .clk(clk), .rst(rst), .launch(launch), .base(wr_base),
      .ready_in(aw_ready), .valid_o(aw_valid), .addr_o(aw_addr), .done_o(aw_done)
   );

   bic_beat_xfer #(.DW(DW), .BEATS(BEATS), .W_REG(W_REG)) u_xfer (
      .clk(clk), .rst(rst), .launch(launch), .enable(enable),
      .r_valid(r_valid), .r_data(r_data), .r_resp(r_resp), .r_ready(r_ready),
      .w_valid(w_valid), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
      .w_ready(w_ready), .last_done(last_done), .rerr(rerr)
   );

   bic_resp_trk u_resp (
      .clk(clk), .rst(rst), .launch(launch), .b_ready(b_ready),
      .b_valid(b_valid), .b_resp(b_resp), .rerr(rerr),
      .code_o(resp_code), .err_o(err_seen), .fin_o(finish)
   );

   logic unused_ok;
   assign unused_ok = ar_done;
endmodule

// File: rtl/burst_incr_copier_chk.sv
module burst_incr_copier_chk #(
   parameter int AW = 32,
   parameter int DW = 64
) (
   input logic          clk,
   input logic          rst,
   input logic          ready,
   input logic          finish,
   input logic          ar_valid,
   input logic          ar_ready,
   input logic [AW-1:0] ar_addr,
   input logic          aw_valid,
   input logic          aw_ready,
   input logic [AW-1:0] aw_addr,
   input logic          w_valid,
   input logic          w_ready,
   input logic [DW-1:0] w_data,
   input logic          w_last,
   input logic          r_ready,
   input logic          b_ready
);
   // R2
   ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));
   // R2
   aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
      aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr));
   // R5
   w_after_aw_chk: assert property (@(posedge clk) disable iff (rst)
      aw_valid |-> !w_valid && !r_ready);
   // R6
   w_hold_chk: assert property (@(posedge clk) disable iff (rst)
      w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last));
   // R7
   b_after_w_chk: assert property (@(posedge clk) disable iff (rst)
      b_ready |-> !w_valid && !ar_valid && !aw_valid);
   // R8
   finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      finish |=> !finish);
   // R8
   finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
      finish |-> ready);
endmodule

bind burst_incr_copier burst_incr_copier_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .ready(ready), .finish(finish),
   .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
   .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
   .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
   .r_ready(r_ready), .b_ready(b_ready)
);

// File: tb/burst_incr_copier_bench.sv
`timescale 1ns/1ps
module burst_incr_copier_bench;
   localparam int BEATS = 256;

   logic        clk = 1'b0;
   logic        rst, start;
   logic [31:0] rd_base, wr_base;
   logic        ready, finish, err_seen;
   logic [1:0]  resp_code;
   logic        ar_valid, ar_ready, aw_valid, aw_ready;
   logic [31:0] ar_addr, aw_addr;
   logic [7:0]  ar_len, aw_len;
   logic [1:0]  ar_burst, aw_burst;
   logic [2:0]  ar_size, aw_size;
   logic        w_valid, w_ready, w_last;
   logic [63:0] w_data;
   logic [7:0]  w_strb;
   logic        r_valid, r_ready;
   logic [63:0] r_data;
   logic [1:0]  r_resp;
   logic        b_valid, b_ready;
   logic [1:0]  b_resp;

   int errors = 0;
   int checks = 0;
   logic [63:0] mem [0:BEATS-1];

   always #5 clk = ~clk;

   burst_incr_copier u_burst_incr_copier (
      .clk(clk), .rst(rst), .start(start), .rd_base(rd_base), .wr_base(wr_base),
      .ready(ready), .finish(finish), .resp_code(resp_code), .err_seen(err_seen),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
      .ar_burst(ar_burst), .ar_size(ar_size),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
      .aw_burst(aw_burst), .aw_size(aw_size),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
      .w_last(w_last), .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
      .r_resp(r_resp), .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit roll(input int pct);
      return ($urandom % 100) < pct;
   endfunction

   function automatic logic [63:0] plus_one(input logic [63:0] v);
      return v + 64'd1;
   endfunction

   task automatic run_op(input logic [31:0] rb, input logic [31:0] wb, input int pct,
                         input int rerr_at, input logic [1:0] bcode, input bit poke,
                         input bit timed, input bit exp_err);
      int rix = 0, wix = 0, ars = 0, aws = 0, fins = 0, bhs = -10, fin_cyc = -1;
      bit rd_on = 0, r_take = 0, b_take = 0, b_done = 0;
      for (int k = 0; k < BEATS; k++) mem[k] = {$urandom, $urandom};
      mem[0] = '1;
      mem[1] = '0;
      mem[BEATS-1] = 64'h7FFF_FFFF_FFFF_FFFF;
      rd_base = rb;
      wr_base = wb;
      for (int cyc = 0; cyc < 30000; cyc++) begin
         @(negedge clk);
         start = (cyc == 0) || (poke && cyc == 60);
         if (r_take) r_valid = 1'b0;
         if (b_take) b_valid = 1'b0;
         r_take = 0;
         b_take = 0;
         ar_ready = roll(pct);
         aw_ready = roll(pct);
         w_ready  = roll(pct);
         if (rd_on && !r_valid && rix < BEATS && roll(pct)) begin
            r_valid = 1'b1;
            r_data  = mem[rix];
            r_resp  = (rix == rerr_at) ? 2'b10 : 2'b00;
         end
         if (wix == BEATS && !b_done && !b_valid && roll(pct)) begin
            b_valid = 1'b1;
            b_resp  = bcode;
         end
         #1;
         if (cyc == 1) begin
            chk(ar_valid && aw_valid, "R2 requests one cycle after start", {ar_valid, aw_valid}, 2'b11);
            chk(!ready, "R11 busy after start", ready, 0);
         end
         if (ar_valid && ar_ready) begin
            ars++;
            rd_on = 1;
            chk(ar_addr == rb, "R2 ar_addr", ar_addr, rb);
            chk({ar_len, ar_burst, ar_size} == {8'(BEATS-1), 2'b01, 3'd3}, "R2 ar fields",
                {ar_len, ar_burst, ar_size}, {8'(BEATS-1), 2'b01, 3'd3});
         end
         if (aw_valid && aw_ready) begin
            aws++;
            chk(aw_addr == wb, "R2 aw_addr", aw_addr, wb);
            chk({aw_len, aw_burst, aw_size} == {8'(BEATS-1), 2'b01, 3'd3}, "R2 aw fields",
                {aw_len, aw_burst, aw_size}, {8'(BEATS-1), 2'b01, 3'd3});
         end
         if (r_valid && r_ready) begin
            r_take = 1;
            rix++;
         end
         if (w_valid && w_ready) begin
            if (wix < BEATS) begin
               chk(w_data == plus_one(mem[wix]), "R3 write data", w_data, plus_one(mem[wix]));
               chk(w_strb == 8'hFF, "R3 strobe", w_strb, 8'hFF);
               chk(w_last == (wix == BEATS-1), "R4 last flag", w_last, (wix == BEATS-1));
            end else begin
               chk(0, "R4 extra write beat", wix, BEATS);
            end
            wix++;
         end
         if (b_valid && b_ready) begin
            chk(wix == BEATS, "R7 response after last beat", wix, BEATS);
            b_take = 1;
            b_done = 1;
            bhs = cyc;
         end
         if (finish) begin
            fins++;
            fin_cyc = cyc;
            chk(cyc == bhs + 1, "R8 finish timing", cyc, bhs + 1);
            chk(ready, "R8 ready with finish", ready, 1);
         end
         if (fin_cyc >= 0 && cyc >= fin_cyc + 3) break;
      end
      start = 1'b0;
      chk(ars == 1 && aws == 1, "R11 single request pair", {ars[15:0], aws[15:0]}, 32'h0001_0001);
      chk(wix == BEATS, "R4 beat count", wix, BEATS);
      chk(fins == 1, "R8 one finish pulse", fins, 1);
      chk(resp_code == bcode, "R7 response code", resp_code, bcode);
      chk(err_seen == exp_err, "R10 sticky error", err_seen, exp_err);
      if (timed) chk(fin_cyc - 1 == BEATS + 3, "R9 stall-free latency", fin_cyc - 1, BEATS + 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h2468));
      rst = 1'b1; start = 1'b0; rd_base = '0; wr_base = '0;
      ar_ready = 0; aw_ready = 0; w_ready = 0;
      r_valid = 0; r_data = '0; r_resp = '0; b_valid = 0; b_resp = '0;
      repeat (4) @(negedge clk);
      #1;
      chk(ready && !finish && !err_seen, "R1 control in reset", {ready, finish, err_seen}, 3'b100);
      chk({ar_valid, aw_valid, w_valid, r_ready, b_ready} == 5'b0, "R1 channels idle in reset",
          {ar_valid, aw_valid, w_valid, r_ready, b_ready}, 0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk(ready && !ar_valid && !aw_valid, "R1 idle after reset", {ready, ar_valid, aw_valid}, 3'b100);
      // Directed: no stalls, clean responses, timed.
      run_op(32'h0000_1000, 32'h0008_0000, 100, -1, 2'b00, 0, 1, 0);
      // Random stalls with one bad read response.
      run_op(32'h0001_2000, 32'h0009_0000, 60, 17, 2'b00, 0, 0, 1);
      // Random stalls, bad write response, start poked while busy.
      run_op(32'h0002_4000, 32'h000A_0000, 45, -1, 2'b10, 1, 0, 1);
      // Clean run clears the sticky flag; timed again.
      run_op(32'h0003_8000, 32'h000B_0000, 100, -1, 2'b00, 0, 1, 0);
      // Heavy stalls with last-beat read error.
      run_op(32'h0004_0000, 32'h000C_0000, 25, BEATS-1, 2'b00, 0, 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule